// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block is the digital control core of a single-row photodiode sensor with 256 pixels. The host gives it a clock and a start strobe. From these it steps a one-hot pixel select bus across the array, one pixel per clock. It also drives two sample/hold controls and an active-low discharge pulse for the integration capacitors. A start strobe begins a readout of the values held from the last exposure and, at the same time, a fresh integration period that runs while the readout goes on.

The last pixel has its own hold control, which trails the shared control of the other pixels by one clock. Because of this, a full line reads out in exactly 256 clocks. A start that arrives during a readout jumps back to the first pixel and leaves the held values alone. If the clock keeps running after the line is done, the select rests on the first pixel in sample mode, so the output tracks that pixel live. Controls that touch analogue nodes change on falling edges. The select advances on rising edges.

Top module: `lsq_readout_seq`

## Requirements
- R1: While reset is low, the select has only bit 0 (pixel 1) high, both hold controls are 0 (sample), the discharge output is 0 (discharging) and the frame-done flag is 0.
- R2: Start sampled high on a rising edge selects pixel 1 from that edge. Each later rising edge without start moves to the next pixel, where select bit k stands for pixel k+1, up to pixel 256.
- R3: Exactly one select bit is high at all times.
- R4: The shared hold control is 1 from the falling edge in each cycle where pixels 1 to 255 are selected. It is 0 from the falling edge in the cycle where pixel 256 is selected, and while the block is idle.
- R5: The last-pixel hold control becomes 1 at the falling edge of the pixel-2 cycle and stays 1 through pixel 256. It returns to 0 one clock after the shared control, at the falling edge of the first cycle that follows a completed line.
- R6: The discharge output is 0 for exactly one clock, from the falling edge of the pixel-2 cycle to the falling edge of the pixel-3 cycle. This holds for every start, including a restart.
- R7: A start seen while pixels 1 to 255 are selected restarts at pixel 1. In that pixel-1 cycle both hold controls keep their values, so nothing is re-sampled.
- R8: After pixel 256, if no start follows, the select stays on pixel 1 and both hold controls stay 0 for as long as the clock runs.
- R9: The frame-done flag is 1 exactly in the cycle where pixel 256 is selected.
- R10: A start seen while pixel 256 is selected begins a normal new line. The last-pixel hold control is 0 in the pixel-1 cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| start | input | 1 | Start strobe, sampled on the rising edge |
| pix_sel | output | NPIX | One-hot pixel select; bit k selects pixel k+1 |
| hold_main | output | 1 | Hold control for pixels 1 to NPIX-1 (1 = hold) |
| hold_last | output | 1 | Hold control for pixel NPIX (1 = hold) |
| int_rst_n | output | 1 | Active-low integration capacitor discharge |
| frame_done | output | 1 | High while the last pixel is selected |

## Verification
Restarts are the hard case, because a start must land in one exact pixel cycle. The most telling slots are pixel 255, pixel 256 and pixel 2, where the pixel-2 restart falls on the discharge pulse itself. Random start strobes seldom hit those exact slots. The bench therefore runs the sequence forward with its own position model until it reaches the cycle just before each target, and then strobes start. After the directed cases it runs a long stretch of sparse random strobes. This stretch covers back-to-back lines, restarts deep inside a line, and long idle tails past the last pixel.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  function automatic int unsigned lsq_pos_w(input int unsigned npix);
    return $clog2(npix + 1);
  endfunction
endpackage

// File: rtl/lsq_rst_sync.sv
module lsq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/lsq_pos_counter.sv
module lsq_pos_counter #(
  parameter int unsigned NPIX = 256,
  parameter int unsigned PW   = lsq_pkg::lsq_pos_w(NPIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [PW-1:0] pos,
  output logic          restart
);
  localparam logic [PW-1:0] LAST = PW'(NPIX);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] pos_nxt;
  logic          restart_nxt;
  logic          pos_en;

  // position 0 is the idle state; 1..NPIX are the pixels of a line
  always_comb begin
    pos_en      = start || (pos != '0);
    restart_nxt = start && (pos != '0) && (pos != LAST);
    if (start)              pos_nxt = ONE;
    else if (pos == LAST)   pos_nxt = '0;
    else                    pos_nxt = pos + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      restart <= 1'b0;
    end else begin
      restart <= restart_nxt;
      if (pos_en) pos <= pos_nxt;
    end
  end

  p_start_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pos == ONE));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && pos != '0 && pos != LAST) |=> (pos == $past(pos) + ONE));

  p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (pos == '0 || pos == LAST)) |=> (pos == '0));
endmodule

// File: rtl/lsq_sel_decode.sv
module lsq_sel_decode #(
  parameter int unsigned NPIX = 256,
  parameter int unsigned PW   = lsq_pkg::lsq_pos_w(NPIX)
) (
  input  logic [PW-1:0]   pos,
  output logic [NPIX-1:0] pix_sel
);
  for (genvar i = 0; i < NPIX; i++) begin : g_sel
    if (i == 0) begin : g_first
      assign pix_sel[i] = (pos == '0) || (pos == PW'(1));
    end else begin : g_rest
      assign pix_sel[i] = (pos == PW'(i + 1));
    end
  end
endmodule

// File: rtl/lsq_hold_ctrl.sv
module lsq_hold_ctrl #(
  parameter int unsigned NPIX = 256,
  parameter int unsigned PW   = lsq_pkg::lsq_pos_w(NPIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pos,
  input  logic          restart,
  output logic          hold_main,
  output logic          hold_last,
  output logic          int_rst_n
);
  localparam logic [PW-1:0] LAST = PW'(NPIX);
  localparam logic [PW-1:0] ONE  = PW'(1);
  localparam logic [PW-1:0] TWO  = PW'(2);

  logic hold_main_nxt;
  logic hold_last_nxt;
  logic int_rst_n_nxt;

  always_comb begin
    hold_main_nxt = (pos != '0) && (pos != LAST);
    if (pos == '0)       hold_last_nxt = 1'b0;
    else if (pos == ONE) hold_last_nxt = restart ? hold_last : 1'b0;
    else                 hold_last_nxt = 1'b1;
    int_rst_n_nxt = (pos != TWO);
  end

  // falling-edge update keeps analogue controls away from select changes
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_main <= 1'b0;
      hold_last <= 1'b0;
      int_rst_n <= 1'b0;
    end else begin
      hold_main <= hold_main_nxt;
      hold_last <= hold_last_nxt;
      int_rst_n <= int_rst_n_nxt;
    end
  end

  p_main_release_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (pos == LAST) |=> !hold_main);

  p_pulse_one_clock_r6: assert property (@(negedge clk) disable iff (!rst_n)
    !int_rst_n |=> int_rst_n);

  p_restart_keeps_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (pos == ONE && restart) |=> (hold_last == $past(hold_last) && hold_main));
endmodule

// File: rtl/lsq_readout_seq.sv
module lsq_readout_seq #(
  parameter int unsigned NPIX = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [NPIX-1:0] pix_sel,
  output logic            hold_main,
  output logic            hold_last,
  output logic            int_rst_n,
  output logic            frame_done
);
  localparam int unsigned   PW   = lsq_pkg::lsq_pos_w(NPIX);
  localparam logic [PW-1:0] LAST = PW'(NPIX);

  logic          rst_sync_n;
  logic [PW-1:0] pos;
  logic          restart;

  lsq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lsq_pos_counter #(.NPIX(NPIX), .PW(PW)) u_pos (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .pos     (pos),
    .restart (restart)
  );

  lsq_sel_decode #(.NPIX(NPIX), .PW(PW)) u_sel (
    .pos     (pos),
    .pix_sel (pix_sel)
  );

  lsq_hold_ctrl #(.NPIX(NPIX), .PW(PW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pos       (pos),
    .restart   (restart),
    .hold_main (hold_main),
    .hold_last (hold_last),
    .int_rst_n (int_rst_n)
  );

  assign frame_done = (pos == LAST);

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(pix_sel) == 1);

  p_done_on_last_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_done |-> pix_sel[NPIX-1]);
endmodule

// File: tb/test_lsq_readout_seq.sv
module test_lsq_readout_seq;
  localparam int N = 256;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [N-1:0] pix_sel;
  logic         hold_main, hold_last, int_rst_n, frame_done;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  // bench model state
  int pm = 0;
  bit rs = 0, hm = 0, hl = 0, ir = 0;

  lsq_readout_seq #(.NPIX(N)) i_lsq_readout_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_sel(pix_sel),
    .hold_main(hold_main), .hold_last(hold_last),
    .int_rst_n(int_rst_n), .frame_done(frame_done)
  );

  initial clk = 0;
  always #4 clk = ~clk;
  always @(posedge clk) cycles++;

  function automatic logic [N-1:0] exp_sel(input int p);
    logic [N-1:0] e;
    e = '0;
    e[(p == 0) ? 0 : p - 1] = 1'b1;
    return e;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pos=%0d actual=%h expected=%h", req, pm, act, exp);
    end
  endtask

  task automatic model_edge(input bit s);
    rs = s && pm >= 1 && pm <= N - 1;
    if (s) pm = 1;
    else if (pm == N) pm = 0;
    else if (pm != 0) pm = pm + 1;
    hm = (pm >= 1 && pm <= N - 1);
    if (pm == 0)      hl = 0;
    else if (pm == 1) hl = rs ? hl : 1'b0;
    else              hl = 1;
    ir = (pm != 2);
  endtask

  task automatic step(input bit s);
    bit cur;
    @(posedge clk);
    cur = start;
    model_edge(cur);
    #2 start = s;
    #4;
    chk("R2 select", pix_sel, exp_sel(pm));
    chk("R3 onehot", N'($countones(pix_sel)), N'(1));
    chk(rs ? "R7 hold_main" : "R4 hold_main", N'(hold_main), N'(hm));
    chk(rs ? "R7 hold_last" : (pm == 1 ? "R10 hold_last" : "R5 hold_last"), N'(hold_last), N'(hl));
    chk("R6 int_rst_n", N'(int_rst_n), N'(ir));
    chk("R9 frame_done", N'(frame_done), N'(pm == N));
    if (pm == 0) chk("R8 idle holds", N'({hold_main, hold_last}), N'(0));
  endtask

  task automatic start_at(input int q);
    while (pm != q - 1) step(1'b0);
    step(1'b1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cycles > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual=%0d expected<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    start = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #6;
    chk("R1 reset sel", pix_sel, exp_sel(0));
    chk("R1 reset holds", N'({hold_main, hold_last}), N'(0));
    chk("R1 reset int_rst_n", N'(int_rst_n), N'(0));
    chk("R1 reset frame_done", N'(frame_done), N'(0));
    @(posedge clk); #2 rst_n = 1;
    repeat (4) @(posedge clk);
    pm = 0; rs = 0; hm = 0; hl = 0; ir = 1;
    // directed: idle, full line, overrun (R8)
    repeat (5) step(1'b0);
    step(1'b1);
    repeat (300) step(1'b0);
    // restart in mid line (R7), at 255, on the discharge cycle, at last pixel (R10)
    start_at(1);
    start_at(100);
    start_at(255);
    start_at(2);
    start_at(N);
    start_at(N);
    repeat (270) step(1'b0);
    // random strobes
    for (int i = 0; i < 30000; i++) begin
      int r;
      r = $urandom % 200;
      step(r == 0);
    end
    repeat (300) step(1'b0);
    done = 1;
    finish_run();
  end
endmodule